// File: doc/BRIEF.md
# Channel Fail Accumulator

This block collects compare failures for a single tester channel. Each clock, the compare logic presents a fail indication and a pattern-driven per-cycle mask. When a failure is recorded, a sticky accumulated fail flag is set and a saturating fail counter advances. A static mask bit in the control register overrides the per-cycle mask and blocks all failure recording.

Software can also advance the counter by one. It does this by writing 1 to a self-clearing increment bit. A second self-clearing bit clears the sticky flag. A small register read port returns the static mask, the flag and the count. The comparators and any fail-capture memory sit outside this block.

Top module: `fail_accum_channel`

## Requirements
- R1: After reset the flag is 0, the count is 0 and the static mask is 0, so failures are recorded.
- R2: A failure (failIn=1) with failMaskIn=0 and the static mask clear is recorded. The flag reads 1 and the count is one higher from the cycle after the clock edge that samples it.
- R3: A failure presented while failMaskIn=1 changes neither the flag nor the count.
- R4: While the static mask (control register at address 0, bit 0) is 1, failures change neither the flag nor the count, whatever the value of failMaskIn.
- R5: Writing 1 to bit 1 of the control register advances the count by exactly one. The change is visible one cycle after the cycle that follows the write edge. Bit 1 always reads back as 0.
- R6: Writing 0 to bit 1 of the control register leaves the count unchanged.
- R7: A recorded failure and a software increment that take effect at the same edge advance the count by two.
- R8: The count is 16 bits wide. It saturates at 0xFFFF and never wraps to a lower value.
- R9: The flag is sticky. It is cleared only by reset or by writing 1 to bit 2 of the control register, which takes effect one edge after the write. If a recorded failure lands on the same edge as the clear, the flag stays 1. Bit 2 always reads back as 0.
- R10: A software increment advances the count even while the static mask is 1.
- R11: Reads are combinational. Address 0 returns the static mask in bit 0. Address 1 returns the flag in bit 0. Address 2 returns the count in bits 15:0. Address 3 returns 0. All unlisted bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| failIn | input | 1 | Per-cycle fail indication from compare logic |
| failMaskIn | input | 1 | Per-cycle pattern fail mask, 1 = ignore this cycle's failure |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Register write address |
| regWrData | input | 16 | Register write data |
| regRdAddr | input | 2 | Register read address |
| regRdData | output | 16 | Register read data |

## Verification
Failures are driven in several patterns: unmasked, masked per cycle, masked statically with the per-cycle mask both low and high, and mixed on alternating cycles. These separate the static override from the dynamic gate. Software increments are issued alone, together with a recorded failure, and while the static mask is set. These patterns distinguish a +1 step from a +2 step and show that the mask does not block software. A long run of failures drives the counter into saturation to expose wrapping. Clear writes are issued both alone and colliding with a failure, to show which of the two wins.

// File: rtl/failacc_pkg.sv
package failacc_pkg;
  localparam int CTRL_ADDR  = 0;
  localparam int FLAG_ADDR  = 1;
  localparam int COUNT_ADDR = 2;

  localparam int MASK_BIT  = 0;
  localparam int BUMP_BIT  = 1;
  localparam int CLEAR_BIT = 2;

  typedef struct packed {
    logic recordFail;
    logic bumpCount;
    logic clearFlag;
  } accStrobes_t;
endpackage

// File: rtl/fail_acc_ctrl.sv
module fail_acc_ctrl
  import failacc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              failIn,
  input  logic              failMaskIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        wrBits,
  output logic              staticMask,
  output accStrobes_t       strobes
);
  logic wrCtrl;
  logic bumpPend;
  logic clearPend;

  assign wrCtrl = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staticMask <= 1'b0;
      bumpPend   <= 1'b0;
      clearPend  <= 1'b0;
    end else begin
      bumpPend  <= wrCtrl && wrBits[BUMP_BIT];
      clearPend <= wrCtrl && wrBits[CLEAR_BIT];
      if (wrCtrl) staticMask <= wrBits[MASK_BIT];
    end
  end

  always_comb begin
    strobes.recordFail = failIn && !failMaskIn && !staticMask;
    strobes.bumpCount  = bumpPend;
    strobes.clearFlag  = clearPend;
  end

  // R5: an increment strobe exists only after a write of 1 to the bump bit
  assert_bump_from_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bumpCount |-> $past(wrEn && (wrAddr == ADDR_W'(CTRL_ADDR)) && wrBits[BUMP_BIT]));

  // R6: a control write with bump bit 0 never yields a strobe next cycle
  assert_zero_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == ADDR_W'(CTRL_ADDR)) && !wrBits[BUMP_BIT]) |=> !strobes.bumpCount);
endmodule

// File: rtl/fail_acc_datapath.sv
module fail_acc_datapath
  import failacc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  accStrobes_t      strobes,
  output logic             failFlag,
  output logic [CNT_W-1:0] failCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]     stepSize;
  logic [CNT_W:0] sumWide;

  always_comb begin
    stepSize = {1'b0, strobes.recordFail} + {1'b0, strobes.bumpCount};
    sumWide  = {1'b0, failCount} + {{(CNT_W-1){1'b0}}, stepSize};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failFlag  <= 1'b0;
      failCount <= '0;
    end else begin
      if (strobes.recordFail)     failFlag <= 1'b1;
      else if (strobes.clearFlag) failFlag <= 1'b0;
      failCount <= sumWide[CNT_W] ? CNT_MAX : sumWide[CNT_W-1:0];
    end
  end

  // R8: the count never goes down
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    failCount >= $past(failCount));

  // R8: once full, the count holds
  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    failCount == CNT_MAX |=> failCount == CNT_MAX);

  // R7: no more than two steps per clock
  assert_max_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (failCount - $past(failCount)) <= CNT_W'(2));

  // R9: flag stays set unless a clear strobe arrives
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strobes.clearFlag) |=> failFlag);
endmodule

// File: rtl/fail_accum_channel.sv
module fail_accum_channel
  import failacc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              failIn,
  input  logic              failMaskIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData
);
  accStrobes_t      strobes;
  logic             staticMask;
  logic             failFlag;
  logic [CNT_W-1:0] failCount;
  logic             unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:3];

  fail_acc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .failIn    (failIn),
    .failMaskIn(failMaskIn),
    .wrEn      (regWrEn),
    .wrAddr    (regWrAddr),
    .wrBits    (regWrData[2:0]),
    .staticMask(staticMask),
    .strobes   (strobes)
  );

  fail_acc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .failFlag (failFlag),
    .failCount(failCount)
  );

  always_comb begin
    regRdData = '0;
    if (regRdAddr == ADDR_W'(CTRL_ADDR))       regRdData[0] = staticMask;
    else if (regRdAddr == ADDR_W'(FLAG_ADDR))  regRdData[0] = failFlag;
    else if (regRdAddr == ADDR_W'(COUNT_ADDR)) regRdData[CNT_W-1:0] = failCount;
  end

  // R3: masked failure without software bump leaves the count alone
  assert_cycle_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    (failMaskIn && !strobes.bumpCount) |=> $stable(failCount));

  // R4: static mask blocks failures from setting the flag
  assert_static_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    (staticMask && failIn && !failFlag) |=> !failFlag);

  // R2: unmasked failure sets the flag on the next cycle
  assert_record_R2: assert property (@(posedge clk) disable iff (!rstN)
    (failIn && !failMaskIn && !staticMask) |=> failFlag);
endmodule

// File: tb/test_fail_accum_channel.sv
`timescale 1ns/1ps
module test_fail_accum_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        failIn = 1'b0;
  logic        failMaskIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrAddr = '0;
  logic [15:0] regWrData = '0;
  logic [1:0]  regRdAddr = '0;
  logic [15:0] regRdData;

  always #5 clk = ~clk;

  fail_accum_channel i_fail_accum_channel (
    .clk(clk), .rstN(rstN), .failIn(failIn), .failMaskIn(failMaskIn),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference
  int mMask = 0, mFlag = 0, mCount = 0, mBump = 0, mClr = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0; mFlag = 0; mCount = 0; mBump = 0; mClr = 0;
    end else begin
      int rec;
      rec = (failIn && !failMaskIn && mMask == 0) ? 1 : 0;
      mCount = mCount + rec + mBump;
      if (mCount > 65535) mCount = 65535;
      if (rec == 1) mFlag = 1;
      else if (mClr == 1) mFlag = 0;
      mBump = (regWrEn && regWrAddr == 2'd0 && regWrData[1]) ? 1 : 0;
      mClr  = (regWrEn && regWrAddr == 2'd0 && regWrData[2]) ? 1 : 0;
      if (regWrEn && regWrAddr == 2'd0) mMask = regWrData[0];
    end
  end

  function automatic int expRead(input logic [1:0] a);
    case (a)
      2'd0: return mMask;
      2'd1: return mFlag;
      2'd2: return mCount;
      default: return 0;
    endcase
  endfunction

  task automatic compareNow();
    int e;
    e = expRead(regRdAddr);
    checks++;
    if (int'(regRdData) != e) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%0h expected=%0h", curReq, regRdAddr, regRdData, e);
    end
  endtask

  // one clock: inputs already set; compare at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compareNow();
  endtask

  // sweep all read addresses without stimulus
  task automatic readAll();
    regWrEn = 0; failIn = 0;
    for (int a = 0; a < 4; a++) begin
      regRdAddr = 2'(a);
      #1 compareNow();
    end
  endtask

  task automatic ctrlWrite(input logic [15:0] d);
    regWrEn = 1; regWrAddr = 2'd0; regWrData = d;
    step();
    regWrEn = 0; regWrData = '0;
  endtask

  task automatic idle(input int n);
    failIn = 0; failMaskIn = 0;
    for (int i = 0; i < n; i++) begin
      regRdAddr = 2'(i % 3);
      step();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    readAll();
    rstN = 1;
    idle(3);
    readAll();

    curReq = "R2";
    regRdAddr = 2'd2;
    failIn = 1; failMaskIn = 0;
    step(); step();
    failIn = 0;
    idle(2);
    readAll();

    curReq = "R9";
    ctrlWrite(16'h0004);
    idle(2);
    readAll();
    ctrlWrite(16'h0004);
    failIn = 1;
    regRdAddr = 2'd1;
    step();
    failIn = 0;
    idle(2);
    readAll();
    ctrlWrite(16'h0004);
    idle(2);

    curReq = "R3";
    failIn = 1; failMaskIn = 1;
    for (int i = 0; i < 6; i++) begin
      regRdAddr = 2'(i % 3);
      step();
    end
    failIn = 0; failMaskIn = 0;
    readAll();

    curReq = "R4";
    ctrlWrite(16'h0001);
    failIn = 1;
    for (int i = 0; i < 8; i++) begin
      failMaskIn = i[0];
      regRdAddr = 2'(i % 3);
      step();
    end
    failIn = 0; failMaskIn = 0;
    readAll();

    curReq = "R10";
    ctrlWrite(16'h0003);
    idle(3);
    readAll();
    ctrlWrite(16'h0000);
    idle(1);

    curReq = "R5";
    ctrlWrite(16'h0002);
    regRdAddr = 2'd2;
    step(); step();
    readAll();

    curReq = "R6";
    ctrlWrite(16'h0000);
    ctrlWrite(16'hFFF8);
    idle(3);
    readAll();

    curReq = "R7";
    ctrlWrite(16'h0002);
    failIn = 1; regRdAddr = 2'd2;
    step();
    failIn = 0;
    step();
    readAll();

    curReq = "R2";
    for (int i = 0; i < 12; i++) begin
      failIn = i[0]; failMaskIn = i[2];
      regRdAddr = 2'(i % 3);
      step();
    end
    failIn = 0; failMaskIn = 0;

    curReq = "R8";
    failIn = 1; regRdAddr = 2'd2;
    for (int i = 0; i < 65545; i++) step();
    ctrlWrite(16'h0002);
    failIn = 1;
    step(); step();
    failIn = 0;
    idle(2);
    readAll();

    curReq = "R11";
    ctrlWrite(16'h0001);
    readAll();
    ctrlWrite(16'h0000);
    readAll();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule